// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock-Out

This block is a 16-bit timer/counter with a companion 16-bit reload/capture register. Software programs it through a byte-wide write port that holds a control byte, a write-one-to-clear flag byte, and the bytes of the counter and the reload register. The counter advances once per machine-cycle tick in timer function. In counter function it advances once for each falling transition of an external count input, sampled on ticks.

Four operating modes are derived from the control byte. Plain auto-reload reloads the counter from the reload register on overflow. Capture copies the running count into the reload register on a falling trigger edge. Up/down reload uses the trigger pin level as the counting direction. Baud-rate generation reloads without setting the overflow flag and emits a one-cycle baud tick. A clock-out pin toggles on each overflow to give a 50% duty clock. The counter and reload values are exposed as outputs for an external read path.

Top module: `tmr16_core`

## Requirements
- R1: After synchronous reset the counter, reload register, control byte, both flags, the clock-out pin and the baud tick are all 0.
- R2: Control byte address 0: bit0 run, bit1 counter function, bit2 capture select, bit3 external enable, bit4 transmit-clock select, bit5 receive-clock select, bit6 up/down enable, bit7 clock-out enable. In timer function with run set, the counter advances by one on each clock where tick is 1. With tick low or run clear it holds.
- R3: In counter function the count input is sampled on every tick. Each 1-to-0 change between two consecutive samples advances the counter once. Changes while tick is low do not count.
- R4: In plain auto-reload mode (bits 2, 4, 5 and 6 clear), advancing from 0xFFFF loads the reload register and sets the overflow flag.
- R5: With bit6 set (and bits 2, 4, 5 clear), the trigger pin selects direction: 1 counts up, 0 counts down. Up overflow from 0xFFFF loads the reload value. Down overflow occurs when advancing while the counter equals the reload value, and it loads 0xFFFF. Each overflow sets the overflow flag and toggles the external flag.
- R6: With bit2 set (bits 4 and 5 clear), the counter wraps from 0xFFFF to 0 and sets the overflow flag. A trigger 1-to-0 edge with bit3 set copies the counter into the reload register and sets the external flag. With bit3 clear, the edge has no effect.
- R7: If bit4 or bit5 is set, the mode is baud generation regardless of bit2. An overflow reloads the counter and pulses the baud tick for one cycle, and it does not set the overflow flag.
- R8: In baud generation, a trigger 1-to-0 edge sets the external flag only when bit3 is set.
- R9: The clock-out pin toggles on each overflow when bit7 is set and bit1 is clear. Otherwise it holds.
- R10: Flags are sticky. Writing address 1 with bit0=1 clears the overflow flag and with bit1=1 clears the external flag. A hardware set in the same cycle wins over the clear.
- R11: Addresses 2/3 write the counter low/high byte and 4/5 the reload low/high byte. A counter write takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Machine-cycle enable |
| cnt_in | input | 1 | External count input |
| trig_in | input | 1 | Trigger edge / direction pin |
| count_o | output | 16 | Current counter value |
| reload_o | output | 16 | Current reload/capture value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external flag |
| baud_tick | output | 1 | One-cycle pulse per baud overflow |
| clk_out | output | 1 | 50% duty clock output |

## Verification
The bench sweeps reload values so that the wrap point, the reload target and the baud period each land on computed values. A design that reloaded one tick early or late, or wrapped to 0 in reload mode, would show a counter off by one or a wrong pulse count. The down-count boundary, where the counter equals the reload value, is hit exactly, catching a design that underflows through zero or reloads the reload value instead of all ones. Every 4-bit count-input pattern is played on ticks, which catches counting on rising edges or on samples taken without a tick. A flag clear is also issued in the very cycle of an overflow, which catches a design where the clear wins.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int TMR_W  = 16;
    localparam int AW     = 3;
    localparam int A_CTRL = 0;
    localparam int A_FLAG = 1;
    localparam int A_CNT  = 2;

    typedef struct packed {
        logic clkout_en;
        logic updown_en;
        logic rx_sel;
        logic tx_sel;
        logic ext_en;
        logic cap_sel;
        logic cnt_mode;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        M_RELOAD  = 2'd0,
        M_UPDOWN  = 2'd1,
        M_CAPTURE = 2'd2,
        M_BAUD    = 2'd3
    } mode_e;

    // Baud selection overrides capture; capture overrides up/down.
    function automatic mode_e pick_mode(ctrl_t c);
        mode_e m;
        if (c.rx_sel || c.tx_sel) m = M_BAUD;
        else if (c.cap_sel)       m = M_CAPTURE;
        else if (c.updown_en)     m = M_UPDOWN;
        else                      m = M_RELOAD;
        return m;
    endfunction

endpackage

// File: rtl/tmr16_fall.sv
module tmr16_fall (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic fall
);
    logic s_q;

    always_ff @(posedge clk) begin
        if (rst)     s_q <= 1'b0;
        else if (en) s_q <= d;
    end

    assign fall = en && s_q && !d;

    // A detected falling edge consumes the high sample, so two in a row cannot occur.
    assert_single_edge_R3: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
    import tmr16_pkg::*;
#(
    parameter int WIDTH = TMR_W,
    parameter int NB    = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             adv,
    input  logic             up,
    input  logic [NB-1:0]    cnt_be,
    input  logic [NB-1:0]    rld_be,
    input  logic [7:0]       wdata,
    input  logic             cap_evt,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] rld_q,
    output logic             ovf_evt
);
    logic [WIDTH-1:0] cnt_n, rld_n;
    logic             adv_eff, down;

    assign adv_eff = adv && !(|cnt_be);
    assign down    = (mode == M_UPDOWN) && !up;
    assign ovf_evt = adv_eff && (down ? (cnt_q == rld_q) : (&cnt_q));

    always_comb begin
        cnt_n = cnt_q;
        if (adv_eff) begin
            if (ovf_evt) begin
                unique case (mode)
                    M_CAPTURE: cnt_n = '0;
                    M_UPDOWN:  cnt_n = down ? '1 : rld_q;
                    default:   cnt_n = rld_q;
                endcase
            end else begin
                cnt_n = down ? cnt_q - WIDTH'(1) : cnt_q + WIDTH'(1);
            end
        end
        for (int b = 0; b < NB; b++)
            if (cnt_be[b]) cnt_n[b*8 +: 8] = wdata;

        rld_n = (cap_evt && !(|rld_be)) ? cnt_q : rld_q;
        for (int b = 0; b < NB; b++)
            if (rld_be[b]) rld_n[b*8 +: 8] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            rld_q <= rld_n;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv && cnt_be == '0) |=> $stable(cnt_q));

    assert_down_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_be == '0 && mode == M_UPDOWN && !up && cnt_q == rld_q) |=> (&cnt_q));

    assert_capture_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && rld_be == '0) |=> (rld_q == $past(cnt_q)));

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int WIDTH  = TMR_W,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              tick,
    input  logic              cnt_in,
    input  logic              trig_in,
    output logic [WIDTH-1:0]  count_o,
    output logic [WIDTH-1:0]  reload_o,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              baud_tick,
    output logic              clk_out
);
    localparam int NB    = WIDTH / 8;
    localparam int A_RLD = A_CNT + NB;

    ctrl_t         ctrl_q;
    mode_e         mode;
    logic [NB-1:0] cnt_be, rld_be;
    logic          cnt_fall, trig_fall, adv, ovf_evt, cap_evt;
    logic          clr_ovf, clr_ext, ext_set, ext_tgl, ovf_set, ext_n;

    // Byte-lane write enables for counter and reload register.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign cnt_be[b] = wr_en && (wr_addr == ADDR_W'(A_CNT + b));
        assign rld_be[b] = wr_en && (wr_addr == ADDR_W'(A_RLD + b));
    end

    assign mode    = pick_mode(ctrl_q);
    assign clr_ovf = wr_en && (wr_addr == ADDR_W'(A_FLAG)) && wr_data[0];
    assign clr_ext = wr_en && (wr_addr == ADDR_W'(A_FLAG)) && wr_data[1];

    tmr16_fall u_cnt_edge (
        .clk (clk), .rst (rst), .en (tick), .d (cnt_in), .fall (cnt_fall)
    );

    tmr16_fall u_trig_edge (
        .clk (clk), .rst (rst), .en (1'b1), .d (trig_in), .fall (trig_fall)
    );

    assign adv = ctrl_q.run && (ctrl_q.cnt_mode ? cnt_fall : tick);

    assign cap_evt = (mode == M_CAPTURE) && ctrl_q.ext_en && trig_fall;
    assign ext_set = ((mode == M_CAPTURE) || (mode == M_BAUD)) && ctrl_q.ext_en && trig_fall;
    assign ext_tgl = (mode == M_UPDOWN) && ovf_evt;
    assign ovf_set = ovf_evt && (mode != M_BAUD);

    tmr16_count #(.WIDTH(WIDTH), .NB(NB)) u_count (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .adv     (adv),
        .up      (trig_in),
        .cnt_be  (cnt_be),
        .rld_be  (rld_be),
        .wdata   (wr_data),
        .cap_evt (cap_evt),
        .cnt_q   (count_o),
        .rld_q   (reload_o),
        .ovf_evt (ovf_evt)
    );

    always_comb begin
        ext_n = clr_ext ? 1'b0 : ext_flag;
        if (ext_tgl) ext_n = !ext_n;
        if (ext_set) ext_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            ovf_flag  <= 1'b0;
            ext_flag  <= 1'b0;
            baud_tick <= 1'b0;
            clk_out   <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(wr_data);
            ovf_flag  <= ovf_set || (ovf_flag && !clr_ovf);
            ext_flag  <= ext_n;
            baud_tick <= ovf_evt && (mode == M_BAUD);
            if (ovf_evt && ctrl_q.clkout_en && !ctrl_q.cnt_mode) clk_out <= !clk_out;
        end
    end

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    assert_baud_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == M_BAUD && !ovf_flag) |=> !ovf_flag);

    assert_clkout_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.clkout_en && !ctrl_q.cnt_mode) |=> $stable(clk_out));

    assert_baud_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> (!baud_tick || mode == M_BAUD));

endmodule

// File: tb/tmr16_core_bench.sv
`timescale 1ns/1ps
module tmr16_core_bench;
    logic        clk = 1'b0;
    logic        rst, wr_en, tick, cnt_in, trig_in;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [15:0] count_o, reload_o;
    logic        ovf_flag, ext_flag, baud_tick, clk_out;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    tmr16_core u_tmr16_core (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .tick (tick), .cnt_in (cnt_in), .trig_in (trig_in),
        .count_o (count_o), .reload_o (reload_o), .ovf_flag (ovf_flag),
        .ext_flag (ext_flag), .baud_tick (baud_tick), .clk_out (clk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick = 1'b0; cnt_in = 1'b0; trig_in = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] base, input logic [15:0] v);
        wr(base, v[7:0]);
        wr(base + 3'd1, v[15:8]);
    endtask

    task automatic run(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rv, expc;
        logic        prev, exp_clk;
        int          pulses;

        // R1: reset state
        @(negedge clk);
        do_reset();
        check("R1 count", count_o, 0);
        check("R1 reload", reload_o, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 ext", ext_flag, 0);
        check("R1 clk_out", clk_out, 0);
        check("R1 baud", baud_tick, 0);

        // R11 write port, R2 timer advance
        wr16(3'd2, 16'h1234);
        check("R11 count write", count_o, 16'h1234);
        wr(3'd0, 8'h01);
        repeat (5) @(negedge clk);
        check("R2 no tick hold", count_o, 16'h1234);
        run(7);
        check("R2 seven ticks", count_o, 16'h123B);
        wr(3'd0, 8'h00);
        run(4);
        check("R2 run clear hold", count_o, 16'h123B);
        wr(3'd3, 8'hAB);
        check("R11 high byte write", count_o, 16'hAB3B);

        // R4 plain auto-reload sweep
        for (int k = 1; k <= 6; k++) begin
            do_reset();
            rv = 16'hFFFF - 16'(k);
            wr16(3'd4, rv);
            wr16(3'd2, 16'hFFFD);
            wr(3'd0, 8'h01);
            run(2);
            check("R4 before wrap", count_o, 16'hFFFF);
            check("R4 no early ovf", ovf_flag, 0);
            run(1);
            check("R4 reload on wrap", count_o, rv);
            check("R4 ovf set", ovf_flag, 1);
            run(k);
            check("R4 after period", count_o, 16'(rv + 16'(k)));
        end

        // R3 counter function over all 4-bit input patterns
        do_reset();
        wr(3'd0, 8'h03);
        prev = 1'b0; expc = '0;
        for (int p = 0; p < 16; p++) begin
            for (int b = 3; b >= 0; b--) begin
                cnt_in = p[b];
                tick = 1'b1;
                @(negedge clk);
                if (prev && !p[b]) expc++;
                prev = p[b];
            end
            tick = 1'b0;
            check("R3 falls counted", count_o, expc);
        end
        for (int i = 0; i < 4; i++) begin
            cnt_in = ~cnt_in;
            @(negedge clk);
        end
        check("R3 no tick no count", count_o, expc);

        // R5 up/down
        do_reset();
        wr16(3'd4, 16'hFFF0);
        wr16(3'd2, 16'hFFFE);
        wr(3'd0, 8'h41);
        run(2);
        check("R5 up reload", count_o, 16'hFFF0);
        check("R5 up ovf", ovf_flag, 1);
        check("R5 ext toggled", ext_flag, 1);
        run(16);
        check("R5 second up reload", count_o, 16'hFFF0);
        check("R5 ext toggled back", ext_flag, 0);
        wr(3'd1, 8'h03);
        trig_in = 1'b0;
        wr16(3'd2, 16'hFFF3);
        run(3);
        check("R5 down count", count_o, 16'hFFF0);
        check("R5 no ovf yet", ovf_flag, 0);
        run(1);
        check("R5 down loads ones", count_o, 16'hFFFF);
        check("R5 down ovf", ovf_flag, 1);
        check("R5 down ext toggle", ext_flag, 1);
        run(1);
        check("R5 keeps counting down", count_o, 16'hFFFE);

        // R6 capture
        do_reset();
        wr(3'd0, 8'h0D);
        wr16(3'd2, 16'h0100);
        run(5);
        check("R6 counting", count_o, 16'h0105);
        trig_in = 1'b0;
        @(negedge clk);
        check("R6 captured", reload_o, 16'h0105);
        check("R6 ext set", ext_flag, 1);
        wr16(3'd2, 16'hFFFF);
        run(1);
        check("R6 wraps to zero", count_o, 16'h0000);
        check("R6 ovf set", ovf_flag, 1);
        check("R6 reload kept", reload_o, 16'h0105);
        // R10 per-flag clear
        wr(3'd1, 8'h01);
        check("R10 ovf cleared", ovf_flag, 0);
        check("R10 ext untouched", ext_flag, 1);
        wr(3'd1, 8'h02);
        check("R10 ext cleared", ext_flag, 0);
        trig_in = 1'b1;
        wr(3'd0, 8'h05);
        @(negedge clk);
        trig_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 no capture without enable", reload_o, 16'h0105);
        check("R6 no ext without enable", ext_flag, 0);

        // R7 baud generation
        do_reset();
        wr16(3'd4, 16'hFFFC);
        wr16(3'd2, 16'hFFFE);
        wr(3'd0, 8'h15);
        run(1);
        check("R7 count", count_o, 16'hFFFF);
        check("R7 no baud yet", baud_tick, 0);
        run(1);
        check("R7 reload despite capture bit", count_o, 16'hFFFC);
        check("R7 baud pulse", baud_tick, 1);
        check("R7 no ovf flag", ovf_flag, 0);
        @(negedge clk);
        check("R7 pulse one cycle", baud_tick, 0);
        for (int j = 0; j < 4; j++) begin
            int per;
            per = (j == 3) ? 5 : j + 1;
            do_reset();
            rv = 16'(65536 - per);
            wr16(3'd4, rv);
            wr16(3'd2, rv);
            wr(3'd0, 8'h21);
            pulses = 0;
            tick = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (baud_tick) pulses++;
            end
            tick = 1'b0;
            check("R7 pulse count per period", pulses, 12 / per);
        end

        // R8 external flag in baud mode
        do_reset();
        wr(3'd0, 8'h29);
        trig_in = 1'b0;
        @(negedge clk);
        check("R8 ext set on edge", ext_flag, 1);
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h21);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 edge ignored without enable", ext_flag, 0);

        // R9 clock-out
        do_reset();
        wr16(3'd4, 16'hFFFE);
        wr16(3'd2, 16'hFFFE);
        wr(3'd0, 8'h81);
        exp_clk = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            run(1);
            if (i % 2 == 0) exp_clk = ~exp_clk;
            check("R9 clk_out toggles", clk_out, exp_clk);
        end
        do_reset();
        wr16(3'd4, 16'hFFFF);
        wr16(3'd2, 16'hFFFF);
        wr(3'd0, 8'h83);
        cnt_in = 1'b1;
        run(1);
        cnt_in = 1'b0;
        run(1);
        check("R9 overflow occurred", ovf_flag, 1);
        check("R9 no toggle in counter function", clk_out, 0);

        // R10 set wins over clear
        do_reset();
        wr16(3'd2, 16'hFFFF);
        wr(3'd0, 8'h01);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h01;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        check("R10 set beats clear", ovf_flag, 1);
        check("R10 reload to zero", count_o, 16'h0000);
        run(3);
        check("R10 sticky", ovf_flag, 1);
        wr(3'd1, 8'h01);
        check("R10 cleared", ovf_flag, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule